// File: doc/BRIEF.md
# Vertical Blanking Pulse Timer

This block produces the vertical blanking interval for a display front end. A digital vertical start signal, already cleaned up from the vertical flyback waveform, starts the pulse on its rising edge. The pulse then lasts for a programmed number of horizontal lines. Each rising edge of the horizontal blanking signal counts as one line. The synchronised start level is also ORed directly onto the output. Blanking therefore begins at once, before the first line tick arrives, and can never be shorter than the start level itself.

The length of the pulse is held in an 8-bit duration register, loaded through a one-cycle write strobe. The block drives two outputs: an active-low blanking pulse for the external driver and an active-high copy for internal use. A watchdog counts horizontal lines with no vertical start edge. When vertical flyback appears to be lost, it raises a no-video flag so that the video path can force black. Both asynchronous inputs pass through two-flop synchronisers, and all edges are detected in the system clock domain.

Top module: `vblank_timer`

## Requirements
- R1: The reset is synchronous and active high. During and after reset, `vblank_o` is 0, `vblank_n_o` is 1 and `novid_o` is 0, and the duration register holds 64 (0x40).
- R2: A rising edge on `vstart_i` that is first sampled high at clock edge n makes `vblank_o` read 1 after clock edge n+1. A falling edge of `vstart_i` never starts a pulse.
- R3: With a nonzero duration D, the pulse ends after the D-th horizontal tick. Only ticks whose `hblank_i` rising edge is first sampled at an edge later than n are counted, and `vblank_o` falls at clock edge m+2, where m is the edge that sampled the D-th counted tick. For example, D = 10, 63 and 127 give pulses of 10, 63 and 127 counted lines.
- R4: `vblank_o` is 1 whenever the synchronised start level is 1, so a start level held longer than the counted length stretches the pulse. The falling edge at the end of a long start level does not start a new pulse.
- R5: While a counted pulse is active, further rising edges on `vstart_i` neither restart nor extend it.
- R6: A duration of 0 gives a pulse that lasts exactly as long as the synchronised start level, with no counted extension.
- R7: When `dur_we_i` is 1 at a clock edge, `dur_wdata_i` is loaded into the duration register. The length is taken from the register at the start edge, so a write made while a pulse is active changes only the next pulse.
- R8: `vblank_n_o` is always the inverse of `vblank_o`.
- R9: `novid_o` rises at clock edge m+2, where m is the edge that sampled the 2048th horizontal tick with no vertical start rising edge since the last one. It stays high after that.
- R10: `novid_o` falls at the clock edge where the next start rising edge is detected, two edges after that edge is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| vstart_i | input | 1 | Vertical start level (asynchronous) |
| hblank_i | input | 1 | Horizontal blanking level, line tick on its rising edge (asynchronous) |
| dur_we_i | input | 1 | Duration register write strobe |
| dur_wdata_i | input | 8 | Duration value in horizontal lines |
| vblank_n_o | output | 1 | Blanking pulse, active low |
| vblank_o | output | 1 | Blanking pulse, active high |
| novid_o | output | 1 | Vertical flyback lost, force video black |

## Verification
Durations of 0 to 5, 7, 10, 63, 127 and 255 are each started at every phase of the start edge relative to a 6-cycle horizontal tick. This separates an off-by-one in the tick count from a tick that lands in the same cycle as the start. Short start levels isolate the counted extension. A long start level with a duration of 1 shows the OR path at work and that a falling edge does not retrigger. Extra start pulses during long pulses show the lockout. A write issued mid-pulse, followed by two pulses, separates the latched length from the live register. A quiet period of just over 2048 ticks locates the no-video flag to the exact clock, and a final start edge shows it clearing.

// File: rtl/vbt_pkg.sv
package vbt_pkg;
    parameter int unsigned VBT_DUR_W = 8;

    typedef logic [VBT_DUR_W-1:0] dur_t;

    typedef struct packed {
        logic active;
        dur_t remain;
        dur_t dur;
    } tmr_state_t;
endpackage

// File: rtl/vbt_sync.sv
module vbt_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign level_o = pipe_q[STAGES-1];
endmodule

// File: rtl/vbt_pulse_core.sv
module vbt_pulse_core
    import vbt_pkg::*;
#(
    parameter int unsigned DUR_RESET = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    input  logic tick_i,
    input  logic wr_en_i,
    input  dur_t wr_data_i,
    output logic active_o,
    output dur_t remain_o,
    output dur_t dur_o
);
    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) st_d.dur = wr_data_i;
        if (st_q.active) begin
            // start edges are locked out here; only line ticks matter
            if (tick_i) begin
                if (st_q.remain == dur_t'(1)) begin
                    st_d.active = 1'b0;
                    st_d.remain = '0;
                end else begin
                    st_d.remain = st_q.remain - dur_t'(1);
                end
            end
        end else if (trig_i && st_q.dur != '0) begin
            st_d.active = 1'b1;
            st_d.remain = st_q.dur;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.active <= 1'b0;
            st_q.remain <= '0;
            st_q.dur    <= dur_t'(DUR_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign remain_o = st_q.remain;
    assign dur_o    = st_q.dur;
endmodule

// File: rtl/vbt_loss_det.sv
module vbt_loss_det #(
    parameter int unsigned LOSS_LINES = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    input  logic tick_i,
    output logic lost_o
);
    localparam int unsigned CW = $clog2(LOSS_LINES + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          lost_d, lost_q;

    always_comb begin
        cnt_d  = cnt_q;
        lost_d = lost_q;
        if (trig_i) begin
            cnt_d  = '0;
            lost_d = 1'b0;
        end else if (tick_i && !lost_q) begin
            if (cnt_q == CW'(LOSS_LINES - 1)) begin
                cnt_d  = CW'(LOSS_LINES);
                lost_d = 1'b1;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            lost_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            lost_q <= lost_d;
        end
    end

    assign lost_o = lost_q;
endmodule

// File: rtl/vblank_timer.sv
module vblank_timer
    import vbt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DUR_RESET   = 64,
    parameter int unsigned LOSS_LINES  = 2048
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vstart_i,
    input  logic       hblank_i,
    input  logic       dur_we_i,
    input  logic [7:0] dur_wdata_i,
    output logic       vblank_n_o,
    output logic       vblank_o,
    output logic       novid_o
);
    localparam int unsigned NSIG = 2;

    logic [NSIG-1:0] sync_lvl;
    logic [NSIG-1:0] prev_d, prev_q;
    logic            vs_lvl, vs_rise, hb_rise;
    logic            tmr_active;
    dur_t            tmr_remain, tmr_dur;

    vbt_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i ({hblank_i, vstart_i}),
        .level_o (sync_lvl)
    );

    always_comb prev_d = sync_lvl;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= prev_d;
    end

    assign vs_lvl  = sync_lvl[0];
    assign vs_rise = sync_lvl[0] & ~prev_q[0];
    assign hb_rise = sync_lvl[1] & ~prev_q[1];

    vbt_pulse_core #(.DUR_RESET(DUR_RESET)) core_i (
        .clk       (clk),
        .rst       (rst),
        .trig_i    (vs_rise),
        .tick_i    (hb_rise),
        .wr_en_i   (dur_we_i),
        .wr_data_i (dur_t'(dur_wdata_i)),
        .active_o  (tmr_active),
        .remain_o  (tmr_remain),
        .dur_o     (tmr_dur)
    );

    vbt_loss_det #(.LOSS_LINES(LOSS_LINES)) loss_i (
        .clk    (clk),
        .rst    (rst),
        .trig_i (vs_rise),
        .tick_i (hb_rise),
        .lost_o (novid_o)
    );

    // raw start level covers the first partial line before counting begins
    assign vblank_o   = tmr_active | vs_lvl;
    assign vblank_n_o = ~vblank_o;
endmodule

// File: rtl/vblank_timer_chk.sv
module vblank_timer_chk
    import vbt_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic vs_rise,
    input logic hb_rise,
    input logic tmr_active,
    input dur_t tmr_remain,
    input dur_t tmr_dur,
    input logic novid_o
);
    // R2
    trig_start_chk: assert property (@(posedge clk) disable iff (rst)
        (vs_rise && !tmr_active && tmr_dur != '0) |=> tmr_active);

    // R3
    end_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(tmr_active)) |-> $past(hb_rise));

    // R5
    no_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_active && vs_rise && !hb_rise) |=> (tmr_remain == $past(tmr_remain)));

    // R6
    zero_dur_chk: assert property (@(posedge clk) disable iff (rst)
        (vs_rise && !tmr_active && tmr_dur == '0) |=> !tmr_active);

    // R9
    novid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(novid_o)) |-> $past(hb_rise));

    // R10
    novid_clear_chk: assert property (@(posedge clk) disable iff (rst)
        vs_rise |=> !novid_o);
endmodule

bind vblank_timer vblank_timer_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .vs_rise    (vs_rise),
    .hb_rise    (hb_rise),
    .tmr_active (tmr_active),
    .tmr_remain (tmr_remain),
    .tmr_dur    (tmr_dur),
    .novid_o    (novid_o)
);

// File: tb/vblank_timer_tb_top.sv
`timescale 1ns/1ps
module vblank_timer_tb_top;
    localparam int P     = 6;
    localparam int LOSSN = 2048;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vstart = 1'b0;
    logic       hblank = 1'b0;
    logic       dur_we = 1'b0;
    logic [7:0] dur_wdata = 8'd0;
    logic       vblank_n, vblank, novid;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int last_n = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    // tick rises are sampled at edges that are multiples of P
    always @(negedge clk) hblank <= (((cyc + 1) % P) < 2);

    vblank_timer dut_i (
        .clk         (clk),
        .rst         (rst),
        .vstart_i    (vstart),
        .hblank_i    (hblank),
        .dur_we_i    (dur_we),
        .dur_wdata_i (dur_wdata),
        .vblank_n_o  (vblank_n),
        .vblank_o    (vblank),
        .novid_o     (novid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr_dur(input int v);
        @(negedge clk);
        dur_we    = 1'b1;
        dur_wdata = 8'(v);
        @(negedge clk);
        dur_we    = 1'b0;
    endtask

    // start one pulse; dur is the length expected for it
    task automatic fire(input int dur, input int phase, input int w,
                        input bit retrig, input int midw, input string req);
        int n, m_end, exp_last, first, cnt, rel;
        bit pol_ok, nv_ok;
        do @(negedge clk); while (((cyc + 1) % P) != phase);
        n = cyc + 1;
        last_n = n;
        vstart = 1'b1;
        m_end = (dur == 0) ? n : ((n / P + dur) * P + 1);
        exp_last = (m_end > n + w) ? m_end : n + w;
        first = -1;
        cnt = 0;
        pol_ok = 1'b1;
        nv_ok = 1'b1;
        while (cyc < exp_last + 6) begin
            @(negedge clk);
            if (vblank) begin
                cnt++;
                if (first < 0) first = cyc;
            end
            if (vblank_n == vblank) pol_ok = 1'b0;
            if (novid) nv_ok = 1'b0;
            rel = cyc + 1 - n;
            vstart = (rel < w) || (retrig && rel >= w + 3 && rel < w + 5);
            if (midw >= 0 && rel == 5) begin
                dur_we    = 1'b1;
                dur_wdata = 8'(midw);
            end else begin
                dur_we    = 1'b0;
            end
        end
        check(first == n + 1, "R2 start cycle", first, n + 1);
        check(cnt == exp_last - n, req, cnt, exp_last - n);
        check(pol_ok, "R8 polarity", int'(pol_ok), 1);
        check(nv_ok, "R9 no early flag", int'(nv_ok), 1);
    endtask

    initial begin
        int durs[11] = '{0, 1, 2, 3, 4, 5, 7, 10, 63, 127, 255};
        int m, n2;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(vblank == 1'b0, "R1 vblank_o in reset", int'(vblank), 0);
        check(vblank_n == 1'b1, "R1 vblank_n_o in reset", int'(vblank_n), 1);
        check(novid == 1'b0, "R1 novid_o in reset", int'(novid), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(vblank == 1'b0, "R1 vblank_o after reset", int'(vblank), 0);
        // R1 default duration 64
        fire(64, 2, 3, 1'b0, -1, "R1 default length");

        // R3 R5 R6 sweep of durations and phases
        foreach (durs[i]) begin
            for (int ph = 0; ph < P; ph++) begin
                wr_dur(durs[i]);
                fire(durs[i], ph, 3, durs[i] >= 3,  -1,
                     (durs[i] == 0) ? "R6 zero length" :
                     (durs[i] >= 3) ? "R3 R5 counted length with retrigger" : "R3 counted length");
            end
        end

        // R4 long start level dominates, fall does not retrigger
        wr_dur(1);
        fire(1, 0, 20, 1'b0, -1, "R4 long level");
        wr_dur(2);
        fire(2, 3, 25, 1'b0, -1, "R4 long level");

        // R7 write during active pulse affects only the next one
        wr_dur(10);
        fire(10, 1, 3, 1'b0, 5, "R7 latched length");
        fire(5, 4, 3, 1'b0, -1, "R7 new length");

        // R9 loss of vertical start
        wr_dur(1);
        fire(1, 0, 3, 1'b0, -1, "R3 counted length");
        m = (last_n / P + LOSSN) * P;
        while (cyc < m + 1) @(negedge clk);
        check(novid == 1'b0, "R9 flag before limit", int'(novid), 0);
        @(negedge clk);
        check(novid == 1'b1, "R9 flag at limit", int'(novid), 1);
        repeat (50) @(negedge clk);
        check(novid == 1'b1, "R9 flag holds", int'(novid), 1);

        // R10 clears on the next start edge
        n2 = cyc + 1;
        vstart = 1'b1;
        while (cyc < n2 + 1) @(negedge clk);
        check(novid == 1'b1, "R10 flag before detect", int'(novid), 1);
        @(negedge clk);
        check(novid == 1'b0, "R10 flag cleared", int'(novid), 0);
        vstart = 1'b0;
        repeat (20) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule